// File: doc/BRIEF.md
# Floating-Point Control/Status Register with Rounding-Mode Resolution

This block keeps the floating-point control and status state of a scalar core in one 8-bit register. The register holds five sticky exception flags and a 3-bit dynamic rounding mode. Software reaches this state through three aliased views on a single CSR access port: flags only, rounding mode only, or both combined. All three views read and write the same storage, so a write through any view is seen by the other two from the next cycle on. The floating-point unit reports new exception flags on its own strobe, and these are ORed into the stored flags.

The block also resolves the rounding-mode field of each floating-point instruction into the mode the arithmetic must use. A field value of 7 selects the stored dynamic mode. Any other value is used as it is. When the resolved mode is one of the reserved encodings, the block raises an illegal-instruction indication. This covers a static field of 5 or 6, and a dynamic request while the stored mode holds 5, 6 or 7.

Top module: `fcsr_unit`

## Requirements
- R1: After reset, the flags and the rounding mode are zero, so every view reads 0.
- R2: The combined view (select 2) reads rounding mode in bits 7:5 and flags in bits 4:0, with NV at bit 4, DZ at bit 3, OF at bit 2, UF at bit 1 and NX at bit 0. The flags view (select 0) reads the flags in bits 4:0, and the rounding-mode view (select 1) reads the mode in bits 2:0. All other read bits are zero.
- R3: A write to the flags view loads wdata[4:0] into the flags and leaves the rounding mode unchanged.
- R4: A write to the rounding-mode view loads the full wdata[2:0] with no masking to 2 bits, and leaves the flags unchanged. Writing 3 makes the combined view read 0x60, and writing 7 makes it read 0xE0.
- R5: A write to the combined view loads wdata[7:5] into the rounding mode and wdata[4:0] into the flags.
- R6: A write is taken at the clock edge where csrValid and csrWrite are both high, and shows in every view after that edge.
- R7: When fpuFlagsValid is high and no flags-touching write occurs, the flags become the old flags ORed with fpuFlags at the clock edge.
- R8: A write to the flags view or the combined view in the same cycle as an accrual wins for the flags. A write to the rounding-mode view does not block accrual.
- R9: An instruction field of 0 to 4 is passed to effRm unchanged, with illegalRm low. Here 0 means nearest-even, 1 toward zero, 2 down, 3 up and 4 nearest-max-magnitude.
- R10: An instruction field of 5 or 6 raises illegalRm.
- R11: An instruction field of 7 makes effRm equal the stored rounding mode. illegalRm is raised exactly when that stored mode is 5, 6 or 7.
- R12: Select 3 is unmapped. It reads zero, and a write to it changes nothing.
- R13: With csrValid low, csrWrite and csrWdata have no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csrValid | input | 1 | CSR access valid |
| csrWrite | input | 1 | CSR access is a write |
| csrSel | input | 2 | View select: 0 flags, 1 rounding mode, 2 combined, 3 unmapped |
| csrWdata | input | 8 | CSR write data |
| csrRdata | output | 8 | CSR read data for the selected view |
| fpuFlagsValid | input | 1 | FPU exception flags strobe |
| fpuFlags | input | 5 | FPU exception flags to accrue |
| instRm | input | 3 | Instruction rounding-mode field |
| effRm | output | 3 | Resolved rounding mode |
| illegalRm | output | 1 | Resolved rounding mode is reserved |

## Verification
The resolver is driven with every static field value from 0 to 7 under a fixed stored mode. It is then driven with the dynamic field against stored modes 3, 5 and 7. This separates pass-through, static-reserved detection and dynamic substitution. A dynamic request with stored 7 must trap, and a static field with stored 7 must not.

The views are written with patterns whose bits differ between fields, such as 0x15 against stored mode bits, and with 7 through the mode view. A write that masked, shifted or leaked into the wrong field would show up in another view. Accrual is exercised alone, against a flags write and against a mode-only write, to tell the two priority cases apart.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;
  localparam int FLAG_W  = 5;
  localparam int RM_W    = 3;
  localparam int STATE_W = FLAG_W + RM_W;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    VIEW_FLAGS = 2'd0,
    VIEW_RM    = 2'd1,
    VIEW_ALL   = 2'd2,
    VIEW_NONE  = 2'd3
  } csrView_e;

  localparam logic [RM_W-1:0] RM_DYN = 3'd7;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrFlags;
    logic wrRm;
    logic fromAll;
    logic accrue;
  } ctrlStrb_t;
endpackage

// File: rtl/fcsr_ctrl.sv
module fcsr_ctrl
  import fcsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrValid,
  input  logic             csrWrite,
  input  logic [SEL_W-1:0] csrSel,
  input  logic             fpuFlagsValid,
  output ctrlStrb_t        strb
);
  csrView_e view;
  logic     wrEn;

  always_comb begin
    view = csrView_e'(csrSel);
    wrEn = csrValid && csrWrite;
    strb.wrFlags = wrEn && (view == VIEW_FLAGS || view == VIEW_ALL);
    strb.wrRm    = wrEn && (view == VIEW_RM    || view == VIEW_ALL);
    strb.fromAll = (view == VIEW_ALL);
    // R8: flags-touching write wins over accrual
    strb.accrue  = fpuFlagsValid && !strb.wrFlags;
  end

  // R13
  no_write_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csrValid |-> (!strb.wrFlags && !strb.wrRm));

  // R12
  none_view_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 2'd3) |-> (!strb.wrFlags && !strb.wrRm));
endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve
  import fcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [RM_W-1:0] instRm,
  input  logic [RM_W-1:0] storedRm,
  output logic [RM_W-1:0] effRm,
  output logic            illegalRm
);
  always_comb begin
    effRm = (instRm == RM_DYN) ? storedRm : instRm;
    unique case (effRm)
      3'd5, 3'd6, 3'd7: illegalRm = 1'b1;
      default:          illegalRm = 1'b0;
    endcase
  end

  // R9
  static_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instRm < 3'd5) |-> (effRm == instRm && !illegalRm));

  // R10
  static_reserved_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instRm == 3'd5 || instRm == 3'd6) |-> illegalRm);

  // R11
  dyn_subst_chk: assert property (@(posedge clk) disable iff (!rstN)
    (instRm == RM_DYN) |-> (effRm == storedRm && illegalRm == (storedRm >= 3'd5)));
endmodule

// File: rtl/fcsr_datapath.sv
module fcsr_datapath
  import fcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [SEL_W-1:0]   csrSel,
  input  logic [STATE_W-1:0] csrWdata,
  input  logic [FLAG_W-1:0]  fpuFlags,
  output logic [FLAG_W-1:0]  flagsQ,
  output logic [RM_W-1:0]    rmQ,
  output logic [STATE_W-1:0] csrRdata
);
  logic [FLAG_W-1:0] flagsD;
  logic [RM_W-1:0]   rmD;

  always_comb begin
    flagsD = flagsQ;
    if (strb.wrFlags)     flagsD = csrWdata[FLAG_W-1:0];
    else if (strb.accrue) flagsD = flagsQ | fpuFlags;
    rmD = rmQ;
    if (strb.wrRm)
      rmD = strb.fromAll ? csrWdata[STATE_W-1:FLAG_W] : csrWdata[RM_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ <= '0;
      rmQ    <= '0;
    end else begin
      flagsQ <= flagsD;
      rmQ    <= rmD;
    end
  end

  always_comb begin
    unique case (csrView_e'(csrSel))
      VIEW_FLAGS: csrRdata = {{(STATE_W-FLAG_W){1'b0}}, flagsQ};
      VIEW_RM:    csrRdata = {{(STATE_W-RM_W){1'b0}}, rmQ};
      VIEW_ALL:   csrRdata = {rmQ, flagsQ};
      default:    csrRdata = '0;
    endcase
  end

  // R4
  rm_full_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRm && !strb.fromAll) |=> rmQ == $past(csrWdata[RM_W-1:0]));

  // R5
  all_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrRm && strb.wrFlags) |=> {rmQ, flagsQ} == $past(csrWdata));

  // R7
  accrue_or_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.accrue |=> flagsQ == ($past(flagsQ) | $past(fpuFlags)));

  // R3
  rm_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrRm |=> $stable(rmQ));

  // R12
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 2'd3) |-> (csrRdata == '0));
endmodule

// File: rtl/fcsr_unit.sv
module fcsr_unit
  import fcsr_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               csrValid,
  input  logic               csrWrite,
  input  logic [SEL_W-1:0]   csrSel,
  input  logic [STATE_W-1:0] csrWdata,
  output logic [STATE_W-1:0] csrRdata,
  input  logic               fpuFlagsValid,
  input  logic [FLAG_W-1:0]  fpuFlags,
  input  logic [RM_W-1:0]    instRm,
  output logic [RM_W-1:0]    effRm,
  output logic               illegalRm
);
  ctrlStrb_t         strb;
  logic [FLAG_W-1:0] flagsQ;
  logic [RM_W-1:0]   rmQ;

  fcsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite),
    .csrSel(csrSel), .fpuFlagsValid(fpuFlagsValid), .strb(strb)
  );

  fcsr_datapath uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .csrSel(csrSel),
    .csrWdata(csrWdata), .fpuFlags(fpuFlags), .flagsQ(flagsQ),
    .rmQ(rmQ), .csrRdata(csrRdata)
  );

  fcsr_rm_resolve uRes (
    .clk(clk), .rstN(rstN), .instRm(instRm), .storedRm(rmQ),
    .effRm(effRm), .illegalRm(illegalRm)
  );

  // R2
  flags_view_alias_chk: assert property (@(posedge clk) disable iff (!rstN)
    (csrSel == 2'd0) |-> (csrRdata == {3'b000, flagsQ}));
endmodule

// File: tb/tb_fcsr_unit.sv
module tb_fcsr_unit;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csrValid = 1'b0, csrWrite = 1'b0;
  logic [1:0] csrSel = 2'd0;
  logic [7:0] csrWdata = 8'd0;
  logic [7:0] csrRdata;
  logic       fpuFlagsValid = 1'b0;
  logic [4:0] fpuFlags = 5'd0;
  logic [2:0] instRm = 3'd0;
  logic [2:0] effRm;
  logic       illegalRm;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  fcsr_unit dut (
    .clk(clk), .rstN(rstN), .csrValid(csrValid), .csrWrite(csrWrite),
    .csrSel(csrSel), .csrWdata(csrWdata), .csrRdata(csrRdata),
    .fpuFlagsValid(fpuFlagsValid), .fpuFlags(fpuFlags),
    .instRm(instRm), .effRm(effRm), .illegalRm(illegalRm)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic csrWr(input logic [1:0] sel, input logic [7:0] data, input bit valid = 1'b1);
    @(negedge clk);
    csrValid = valid; csrWrite = 1'b1; csrSel = sel; csrWdata = data;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0; csrWdata = 8'd0;
  endtask

  task automatic csrRd(input logic [1:0] sel, output logic [7:0] val);
    csrSel = sel; csrValid = 1'b1; csrWrite = 1'b0;
    #1;
    val = csrRdata;
    csrValid = 1'b0;
  endtask

  task automatic testReset();
    logic [7:0] v;
    for (int s = 0; s < 4; s++) begin
      csrRd(2'(s), v);
      check("R1 reset view", v, 0);
    end
  endtask

  task automatic testFlagsView();
    logic [7:0] v;
    csrWr(2'd1, 8'h02);
    csrWr(2'd0, 8'hF5);           // upper bits must be dropped
    csrRd(2'd0, v); check("R3 flags view", v, 8'h15);
    csrRd(2'd1, v); check("R3 rm kept", v, 8'h02);
    csrRd(2'd2, v); check("R2 combined layout", v, 8'h55);
  endtask

  task automatic testRmView();
    logic [7:0] v;
    csrWr(2'd2, 8'h00);
    csrWr(2'd1, 8'h03);
    csrRd(2'd2, v); check("R4 rm=3 combined", v, 8'h60);
    csrWr(2'd1, 8'h07);
    csrRd(2'd2, v); check("R4 rm=7 combined", v, 8'hE0);
    csrRd(2'd1, v); check("R4 rm view full width", v, 8'h07);
    csrRd(2'd0, v); check("R4 flags kept", v, 8'h00);
  endtask

  task automatic testCombined();
    logic [7:0] v;
    csrWr(2'd2, 8'h8A);
    csrRd(2'd0, v); check("R5 flags from combined", v, 8'h0A);
    csrRd(2'd1, v); check("R5 rm from combined", v, 8'h04);
    // R6: visible only after the edge
    @(negedge clk);
    csrValid = 1'b1; csrWrite = 1'b1; csrSel = 2'd2; csrWdata = 8'h21;
    #1; check("R6 not before edge", csrRdata, 8'h8A);
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0;
    #1; check("R6 after edge", csrRdata, 8'h21);
  endtask

  task automatic testAccrual();
    logic [7:0] v;
    csrWr(2'd2, 8'h01);
    @(negedge clk); fpuFlagsValid = 1'b1; fpuFlags = 5'h12;
    @(negedge clk); fpuFlagsValid = 1'b0; fpuFlags = 5'h00;
    csrRd(2'd2, v); check("R7 accrue OR", v, 8'h13);
  endtask

  task automatic testPriority();
    logic [7:0] v;
    csrWr(2'd2, 8'h00);
    @(negedge clk);
    csrValid = 1'b1; csrWrite = 1'b1; csrSel = 2'd0; csrWdata = 8'h01;
    fpuFlagsValid = 1'b1; fpuFlags = 5'h10;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0; fpuFlagsValid = 1'b0; fpuFlags = 5'h00;
    csrRd(2'd0, v); check("R8 write beats accrue", v, 8'h01);
    @(negedge clk);
    csrValid = 1'b1; csrWrite = 1'b1; csrSel = 2'd1; csrWdata = 8'h02;
    fpuFlagsValid = 1'b1; fpuFlags = 5'h08;
    @(negedge clk);
    csrValid = 1'b0; csrWrite = 1'b0; fpuFlagsValid = 1'b0; fpuFlags = 5'h00;
    csrRd(2'd2, v); check("R8 rm write keeps accrue", v, 8'h49);
  endtask

  task automatic testStaticRm();
    csrWr(2'd1, 8'h07);
    for (int m = 0; m < 7; m++) begin
      instRm = 3'(m); #1;
      if (m < 5) begin
        check("R9 static effRm", effRm, m);
        check("R9 static legal", illegalRm, 0);
      end else begin
        check("R10 static reserved", illegalRm, 1);
      end
    end
  endtask

  task automatic testDynamic();
    logic [2:0] modes [3] = '{3'd3, 3'd5, 3'd7};
    foreach (modes[i]) begin
      csrWr(2'd1, {5'd0, modes[i]});
      instRm = 3'd7; #1;
      check("R11 dyn effRm", effRm, modes[i]);
      check("R11 dyn illegal", illegalRm, (modes[i] >= 3'd5) ? 1 : 0);
    end
    instRm = 3'd2; #1;
    check("R11 static with stored 7", illegalRm, 0);
    instRm = 3'd0;
  endtask

  task automatic testUnmapped();
    logic [7:0] v;
    csrWr(2'd2, 8'h4C);
    csrWr(2'd3, 8'hFF);
    csrRd(2'd3, v); check("R12 unmapped read", v, 8'h00);
    csrRd(2'd2, v); check("R12 unmapped write ignored", v, 8'h4C);
    csrWr(2'd2, 8'hFF, 1'b0);
    csrRd(2'd2, v); check("R13 no valid no write", v, 8'h4C);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFlagsView();
    testRmView();
    testCombined();
    testAccrual();
    testPriority();
    testStaticRm();
    testDynamic();
    testUnmapped();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule